// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is a purely combinational arithmetic/logic unit for an integer datapath that handles both byte and word operands. A width input picks 8-bit or 16-bit operation for each request. From two operands, an operation code and the incoming status flags, the block returns a result, six new status flags and a write-enable. The write-enable tells the caller whether the result goes back to the destination.

The six flags are auxiliary carry, carry, overflow, sign, parity and zero. Each is computed at the selected width. The caller registers the flag outputs and feeds them back on the flag input, which is where add-with-carry and subtract-with-borrow take their carry-in.

Operation codes:

| Code | Operation | Code | Operation |
|---|---|---|---|
| 0 | ADD | 7 | DEC |
| 1 | ADC | 8 | AND |
| 2 | SUB | 9 | OR |
| 3 | SBB | 10 | XOR |
| 4 | CMP | 11 | NOT |
| 5 | NEG | 12 | TEST |
| 6 | INC | 13–15 | unused |

Flag vector bit order: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow.

Top module: `bw_alu`

## Requirements
- R1: When `is_word` is 0, only the low 8 bits of each operand are used, `alu_res[15:8]` is 0, and every flag is taken at bit 7 and below. When `is_word` is 1, all 16 bits are used.
- R2: ADD gives a+b and ADC gives a+b+CFin, where CFin is `flag_in[0]`. Carry (`flag_out[0]`) is the carry out of the top bit at the selected width.
- R3: SUB gives a-b and SBB gives a-b-CFin. CMP computes a-b and presents it on `alu_res`. For all three, carry is set on a borrow into the top bit.
- R4: For the arithmetic operations, auxiliary carry (`flag_out[2]`) is set on a carry out of bit 3 or a borrow into bit 3. For AND, OR, XOR and TEST it is 0.
- R5: Overflow (`flag_out[5]`) is set on signed overflow. For an add, both operands have the same sign and the result sign differs. For a subtract, the operand signs differ and the result sign differs from a.
- R6: For every operation that updates flags, sign (`flag_out[4]`) equals the top result bit at the width, zero (`flag_out[3]`) is set when the result is 0, and parity (`flag_out[1]`) is set when `alu_res[7:0]` holds an even number of ones.
- R7: `wr_en` is 0 for CMP, for TEST and for the unused codes, and 1 for every other operation. TEST presents a AND b on `alu_res`. The unused codes give a result of 0 and `flag_out` equal to `flag_in`.
- R8: NEG gives 0-a in two's complement, with flags as for subtracting a from zero, and ignores b.
- R9: INC gives a+1 and DEC gives a-1. Both update every flag except carry, which is copied from `flag_in[0]`.
- R10: AND, OR and XOR produce the bitwise result and clear carry and overflow. NOT produces the complement of a and `flag_out` equals `flag_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_word | input | 1 | 1 for 16-bit operation, 0 for 8-bit |
| op_code | input | 4 | Operation select, coded as in the table above |
| opnd_a | input | 16 | Destination / first operand |
| opnd_b | input | 16 | Source / second operand |
| flag_in | input | 6 | Current status flags; bit 0 is the carry-in |
| alu_res | output | 16 | Result; upper byte is 0 in byte mode |
| flag_out | output | 6 | New status flags |
| wr_en | output | 1 | Result should be written to the destination |

## Verification
The checker assumes that every input is driven to a known value and that the inputs settle together before outputs are judged. It also assumes that codes 13 to 15 are legal stimulus with the pass-through behaviour described in R7. The bench changes all inputs in one step just after a rising edge and compares only at the following falling edge, so no transient combination is ever scored. Random operands are masked to nothing, so byte mode always sees upper-byte noise that must not leak into the result or flags.

// File: rtl/bw_alu_pkg.sv
`timescale 1ns/1ps
package bw_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_NEG  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_TEST = 4'd12
    } alu_op_e;

    // how the flag unit treats an operation
    typedef enum logic [1:0] {
        CLS_ARITH,  // all six flags from the adder
        CLS_KEEPC,  // as arith, carry passes through
        CLS_LOGIC,  // carry/overflow/aux cleared
        CLS_HOLD    // flags pass through unchanged
    } flag_cls_e;

    localparam int FLG_CF = 0;
    localparam int FLG_PF = 1;
    localparam int FLG_AF = 2;
    localparam int FLG_ZF = 3;
    localparam int FLG_SF = 4;
    localparam int FLG_OF = 5;
    localparam int FLG_W  = 6;

endpackage

// File: rtl/bw_alu_addsub.sv
`timescale 1ns/1ps
module bw_alu_addsub #(
    parameter int DW = 16
) (
    input  logic          is_word,
    input  logic          do_sub,
    input  logic          cin,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    output logic [DW-1:0] sum_o,
    output logic          cy_o,
    output logic          ax_o,
    output logic          ov_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] y_eff;
    logic [4:0]    nib_sum;
    logic [HW:0]   half_sum;
    logic [DW:0]   full_sum;
    logic          raw_cy;
    logic          sx, sy, sr;

    always_comb begin
        y_eff    = do_sub ? ~y_in : y_in;
        nib_sum  = {1'b0, x_in[3:0]} + {1'b0, y_eff[3:0]} + {4'b0, cin};
        half_sum = {1'b0, x_in[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, cin};
        full_sum = {1'b0, x_in} + {1'b0, y_eff} + {{DW{1'b0}}, cin};
        if (is_word) begin
            sum_o  = full_sum[DW-1:0];
            raw_cy = full_sum[DW];
            sx     = x_in[DW-1];
            sy     = y_eff[DW-1];
            sr     = full_sum[DW-1];
        end else begin
            sum_o  = {{(DW-HW){1'b0}}, half_sum[HW-1:0]};
            raw_cy = half_sum[HW];
            sx     = x_in[HW-1];
            sy     = y_eff[HW-1];
            sr     = half_sum[HW-1];
        end
        // subtraction reports borrow, the inverse of the adder carry
        cy_o = raw_cy ^ do_sub;
        ax_o = nib_sum[4] ^ do_sub;
        ov_o = (sx == sy) && (sr != sx);
    end

endmodule

// File: rtl/bw_alu_logic.sv
`timescale 1ns/1ps
module bw_alu_logic
    import bw_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          is_word,
    input  alu_op_e       op_sel,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] res_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] raw;

    always_comb begin
        unique case (op_sel)
            OP_AND, OP_TEST: raw = a_in & b_in;
            OP_OR:           raw = a_in | b_in;
            OP_XOR:          raw = a_in ^ b_in;
            OP_NOT:          raw = ~a_in;
            default:         raw = '0;
        endcase
        res_o = is_word ? raw : {{(DW-HW){1'b0}}, raw[HW-1:0]};
    end

endmodule

// File: rtl/bw_alu_flags.sv
`timescale 1ns/1ps
module bw_alu_flags
    import bw_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             is_word,
    input  flag_cls_e        cls,
    input  logic [DW-1:0]    res_in,
    input  logic             cy_in,
    input  logic             ax_in,
    input  logic             ov_in,
    input  logic [FLG_W-1:0] flag_prev,
    output logic [FLG_W-1:0] flag_new
);
    localparam int HW = DW / 2;

    logic sgn, zer, par;

    always_comb begin
        sgn = is_word ? res_in[DW-1] : res_in[HW-1];
        zer = (res_in == '0);
        par = ~^res_in[7:0];
        flag_new = flag_prev;
        unique case (cls)
            CLS_ARITH, CLS_KEEPC: begin
                flag_new[FLG_CF] = (cls == CLS_KEEPC) ? flag_prev[FLG_CF] : cy_in;
                flag_new[FLG_AF] = ax_in;
                flag_new[FLG_OF] = ov_in;
                flag_new[FLG_SF] = sgn;
                flag_new[FLG_ZF] = zer;
                flag_new[FLG_PF] = par;
            end
            CLS_LOGIC: begin
                flag_new[FLG_CF] = 1'b0;
                flag_new[FLG_AF] = 1'b0;
                flag_new[FLG_OF] = 1'b0;
                flag_new[FLG_SF] = sgn;
                flag_new[FLG_ZF] = zer;
                flag_new[FLG_PF] = par;
            end
            default: flag_new = flag_prev;
        endcase
    end

endmodule

// File: rtl/bw_alu.sv
`timescale 1ns/1ps
module bw_alu
    import bw_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             is_word,
    input  logic [3:0]       op_code,
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    input  logic [FLG_W-1:0] flag_in,
    output logic [DW-1:0]    alu_res,
    output logic [FLG_W-1:0] flag_out,
    output logic             wr_en
);
    alu_op_e       op_e;
    logic [DW-1:0] x_sel, y_sel;
    logic          do_sub, cin, use_logic, zero_res;
    flag_cls_e     cls;

    logic [DW-1:0] arith_res, logic_res;
    logic          cy, ax, ov;

    // operand routing and control decode
    always_comb begin
        op_e      = alu_op_e'(op_code);
        x_sel     = opnd_a;
        y_sel     = opnd_b;
        do_sub    = 1'b0;
        cin       = 1'b0;
        use_logic = 1'b0;
        zero_res  = 1'b0;
        cls       = CLS_ARITH;
        wr_en     = 1'b1;
        unique case (op_e)
            OP_ADD: ;
            OP_ADC: cin = flag_in[FLG_CF];
            OP_SUB: begin do_sub = 1'b1; cin = 1'b1; end
            OP_SBB: begin do_sub = 1'b1; cin = ~flag_in[FLG_CF]; end
            OP_CMP: begin do_sub = 1'b1; cin = 1'b1; wr_en = 1'b0; end
            OP_NEG: begin
                x_sel  = '0;
                y_sel  = opnd_a;
                do_sub = 1'b1;
                cin    = 1'b1;
            end
            OP_INC: begin
                y_sel = {{(DW-1){1'b0}}, 1'b1};
                cls   = CLS_KEEPC;
            end
            OP_DEC: begin
                y_sel  = {{(DW-1){1'b0}}, 1'b1};
                do_sub = 1'b1;
                cin    = 1'b1;
                cls    = CLS_KEEPC;
            end
            OP_AND, OP_OR, OP_XOR: begin
                use_logic = 1'b1;
                cls       = CLS_LOGIC;
            end
            OP_TEST: begin
                use_logic = 1'b1;
                cls       = CLS_LOGIC;
                wr_en     = 1'b0;
            end
            OP_NOT: begin
                use_logic = 1'b1;
                cls       = CLS_HOLD;
            end
            default: begin
                zero_res = 1'b1;
                cls      = CLS_HOLD;
                wr_en    = 1'b0;
            end
        endcase
    end

    bw_alu_addsub #(.DW(DW)) u_addsub (
        .is_word (is_word),
        .do_sub  (do_sub),
        .cin     (cin),
        .x_in    (x_sel),
        .y_in    (y_sel),
        .sum_o   (arith_res),
        .cy_o    (cy),
        .ax_o    (ax),
        .ov_o    (ov)
    );

    bw_alu_logic #(.DW(DW)) u_logic (
        .is_word (is_word),
        .op_sel  (op_e),
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .res_o   (logic_res)
    );

    always_comb begin
        if (zero_res)       alu_res = '0;
        else if (use_logic) alu_res = logic_res;
        else                alu_res = arith_res;
    end

    bw_alu_flags #(.DW(DW)) u_flags (
        .is_word   (is_word),
        .cls       (cls),
        .res_in    (alu_res),
        .cy_in     (cy),
        .ax_in     (ax),
        .ov_in     (ov),
        .flag_prev (flag_in),
        .flag_new  (flag_out)
    );

endmodule

// File: rtl/bw_alu_chk.sv
`timescale 1ns/1ps
module bw_alu_chk
    import bw_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input logic             is_word,
    input logic [3:0]       op_code,
    input logic [DW-1:0]    opnd_a,
    input logic [DW-1:0]    opnd_b,
    input logic [FLG_W-1:0] flag_in,
    input logic [DW-1:0]    alu_res,
    input logic [FLG_W-1:0] flag_out,
    input logic             wr_en
);
    localparam int HW = DW / 2;

    logic known, sets_flags;

    always_comb begin
        known      = !$isunknown({is_word, op_code, opnd_a, opnd_b, flag_in});
        sets_flags = (op_code <= 4'd12) && (op_code != 4'd11);
        if (known) begin
            // R7: compare and test never request a write
            assert_no_write_R7: assert (!((op_code == 4'd4 || op_code == 4'd12) && wr_en))
                else $error("cmp/test asserted write enable");
            // R9: increment/decrement carry comes from the input flags
            assert_keep_carry_R9: assert (!((op_code == 4'd6 || op_code == 4'd7)
                                            && (flag_out[FLG_CF] != flag_in[FLG_CF])))
                else $error("inc/dec disturbed carry");
            // R10: complement leaves every flag alone
            assert_not_hold_R10: assert (!(op_code == 4'd11 && flag_out != flag_in))
                else $error("not changed flags");
            // R10: bitwise ops clear carry and overflow
            assert_logic_clear_R10: assert (!((op_code == 4'd8 || op_code == 4'd9 ||
                                               op_code == 4'd10 || op_code == 4'd12) &&
                                              (flag_out[FLG_CF] || flag_out[FLG_OF])))
                else $error("logic op left carry/overflow set");
            // R1: byte mode keeps the upper result byte clear
            assert_byte_upper_R1: assert (is_word || alu_res[DW-1:HW] == '0)
                else $error("byte result leaked into upper byte");
            // R6: zero flag agrees with the presented result
            assert_zero_flag_R6: assert (!sets_flags || (flag_out[FLG_ZF] == (alu_res == '0)))
                else $error("zero flag disagrees with result");
        end
    end

endmodule

bind bw_alu bw_alu_chk #(.DW(DW)) u_chk (
    .is_word  (is_word),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .flag_in  (flag_in),
    .alu_res  (alu_res),
    .flag_out (flag_out),
    .wr_en    (wr_en)
);

// File: tb/tb_bw_alu.sv
`timescale 1ns/1ps
module tb_bw_alu;

    typedef struct {
        logic [15:0] res;
        logic [5:0]  flg;
        logic        wr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        is_word = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] opnd_b = 16'd0;
    logic [5:0]  flag_in = 6'd0;
    logic [15:0] alu_res;
    logic [5:0]  flag_out;
    logic        wr_en;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;  // 125 MHz

    bw_alu dut (
        .is_word  (is_word),
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .flag_in  (flag_in),
        .alu_res  (alu_res),
        .flag_out (flag_out),
        .wr_en    (wr_en)
    );

    function automatic bit even_par(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2) == 0;
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(bit wd, logic [3:0] op, logic [15:0] a,
                                   logic [15:0] b, logic [5:0] fin, string tag);
        exp_t e;
        int   mask, msb, x, y, c, r;
        bit   cf, af, of, sub, keepc, lg, hold;
        mask = wd ? 32'hFFFF : 32'hFF;
        msb  = wd ? 32'h8000 : 32'h80;
        x = int'(a) & mask;
        y = int'(b) & mask;
        c = 0; r = 0; cf = 0; af = 0; of = 0;
        sub = 0; keepc = 0; lg = 0; hold = 0;
        e.wr = 1'b1;
        case (op)
            4'd0: ;
            4'd1: c = int'(fin[0]);
            4'd2: sub = 1;
            4'd3: begin sub = 1; c = int'(fin[0]); end
            4'd4: begin sub = 1; e.wr = 1'b0; end
            4'd5: begin y = x; x = 0; sub = 1; end
            4'd6: begin y = 1; keepc = 1; end
            4'd7: begin y = 1; sub = 1; keepc = 1; end
            4'd8:  begin lg = 1; r = x & y; end
            4'd9:  begin lg = 1; r = x | y; end
            4'd10: begin lg = 1; r = x ^ y; end
            4'd11: begin hold = 1; r = ~x & mask; end
            4'd12: begin lg = 1; r = x & y; e.wr = 1'b0; end
            default: begin hold = 1; r = 0; e.wr = 1'b0; end
        endcase
        if (hold) begin
            e.flg = fin;
        end else if (lg) begin
            e.flg = {1'b0, (r & msb) != 0, r == 0, 1'b0, even_par(r), 1'b0};
        end else begin
            if (sub) begin
                r  = (x - y - c) & mask;
                cf = x < (y + c);
                af = (x & 15) < ((y & 15) + c);
                of = ((x ^ y) & (x ^ r) & msb) != 0;
            end else begin
                r  = (x + y + c) & mask;
                cf = (x + y + c) > mask;
                af = ((x & 15) + (y & 15) + c) > 15;
                of = ((x ^ r) & (y ^ r) & msb) != 0;
            end
            if (keepc) cf = fin[0];
            e.flg = {of, (r & msb) != 0, r == 0, af, even_par(r), cf};
        end
        e.res = r[15:0];
        e.tag = tag;
        return e;
    endfunction

    // driver: apply one request per cycle, queue its expectation
    task automatic drive(bit wd, logic [3:0] op, logic [15:0] a, logic [15:0] b,
                         logic [5:0] fin, string tag);
        @(posedge clk);
        #1;
        is_word = wd;
        op_code = op;
        opnd_a  = a;
        opnd_b  = b;
        flag_in = fin;
        sb_q.push_back(model(wd, op, a, b, fin, tag));
    endtask

    // monitor: compare at the falling edge after each request
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (alu_res !== e.res || flag_out !== e.flg || wr_en !== e.wr) begin
                bad++;
                $display("FAIL %s: got res=%h flg=%b wr=%b exp res=%h flg=%b wr=%b",
                         e.tag, alu_res, flag_out, wr_en, e.res, e.flg, e.wr);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R6 quiet start: zero plus zero sets zero and parity
        drive(0, 4'd0, 16'h0000, 16'h0000, 6'h00, "R6 zero start");
        drive(0, 4'd0, 16'h00FF, 16'h0001, 6'h00, "R2 byte add carry");
        drive(1, 4'd0, 16'hFFFF, 16'h0001, 6'h00, "R2 word add carry");
        drive(1, 4'd1, 16'h1234, 16'h1111, 6'h01, "R2 adc carry-in");
        drive(0, 4'd0, 16'h007F, 16'h0001, 6'h00, "R5 byte add overflow");
        drive(1, 4'd2, 16'h8000, 16'h0001, 6'h00, "R5 word sub overflow");
        drive(0, 4'd2, 16'h0010, 16'h0001, 6'h00, "R4 nibble borrow");
        drive(0, 4'd0, 16'h0008, 16'h0008, 6'h00, "R4 nibble carry");
        drive(0, 4'd3, 16'h0005, 16'h0005, 6'h01, "R3 sbb borrow");
        drive(1, 4'd3, 16'h0005, 16'h0003, 6'h00, "R3 sbb no borrow-in");
        drive(1, 4'd4, 16'h0003, 16'h0005, 6'h00, "R7 cmp no write");
        drive(0, 4'd12, 16'h00F0, 16'h000F, 6'h3F, "R7 test no write");
        drive(1, 4'd13, 16'h1234, 16'h5678, 6'h2A, "R7 unused code");
        drive(0, 4'd5, 16'h0080, 16'hFFFF, 6'h00, "R8 neg min");
        drive(1, 4'd5, 16'h0000, 16'h1234, 6'h01, "R8 neg zero");
        drive(0, 4'd6, 16'h00FF, 16'h0000, 6'h00, "R9 inc wrap");
        drive(1, 4'd7, 16'h0000, 16'h0000, 6'h01, "R9 dec wrap");
        drive(1, 4'd6, 16'h7FFF, 16'h0000, 6'h01, "R9 inc overflow");
        drive(1, 4'd8, 16'hF0F0, 16'hFF00, 6'h3F, "R10 and");
        drive(1, 4'd9, 16'h0F00, 16'h00F0, 6'h3F, "R10 or");
        drive(0, 4'd10, 16'h00AA, 16'h00AA, 6'h3F, "R10 xor");
        drive(1, 4'd11, 16'h1234, 16'h0000, 6'h15, "R10 not holds flags");
        drive(0, 4'd0, 16'hAB01, 16'hCD02, 6'h00, "R1 upper bytes ignored");
        drive(0, 4'd11, 16'hFF00, 16'h0000, 6'h00, "R1 byte not");
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 300; i++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            drive(lfsr[31], lfsr[3:0], lfsr[27:12], lfsr[19:4] ^ 16'h5A3C, lfsr[9:4],
                  "R1 R2 R3 R4 R5 R6 random");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule